// File: doc/BRIEF.md
# Complementary Half-Bridge PWM with Turn-On Dead Time

This block produces two active-high drive signals for a push-pull half-bridge. A free-running counter sweeps from zero up to a programmed terminal value, and this sets the PWM period. A compare value sets how long the high-side drive is active at the start of each period. The low-side drive covers the remainder of the period. Each side has its own dead-time state machine. It holds back that side's rising edge by a programmed number of clock cycles. Falling edges are never delayed, so the two switches are never commanded on together.

The period, compare and dead-time values are captured into shadow registers. The capture happens at the end of a period, or at any time while the block is disabled, so a write in mid-period cannot cut a pulse short. The timebase state machine has two states. HALT is entered on reset or when enable is low; in HALT the count is zero, the shadows follow the inputs and both drives are off. RUN is where counting happens. The transitions are START (HALT to RUN when enable is high) and STOP (RUN to HALT when enable is low).

Each dead-time machine has three states. IDLE means the ideal window is inactive and the run counter is zero. WAIT means the window is active and the counter is still climbing. FULL means the counter has saturated at its maximum. The transitions are OPEN (IDLE to WAIT, or to FULL when the maximum is reached at once), SATURATE (WAIT to FULL) and ABORT (WAIT or FULL back to IDLE when the window ends or the block is cleared).

Top module: `cpwm_halfbridge`

## Requirements
- R1: With terminal value P, the counter visits 0,1,...,P and then returns to 0, so one period lasts P+1 cycles. Successive delayed rising edges of the high-side drive are P+1 cycles apart.
- R2: With compare value D, the high side's ideal window is the set of counts c with c < D. With dead time zero, the high-side drive equals that window.
- R3: With dead time B, a drive goes high only once its ideal window has been continuously active for B cycles, counted from the cycle in which the window opens. It drops in the same cycle the window closes.
- R4: If B is at least the length of a side's ideal window, that side stays low for the whole period, and its delay counter returns to zero once the window ends.
- R5: The high-side and low-side drives are never high in the same cycle.
- R6: The low side's ideal window is the set of counts c with c >= D. With B = 0, exactly one drive is high in every running cycle.
- R7: D = 0 keeps the high side low for the whole period. D > P keeps the low side low for the whole period.
- R8: P, D and B take effect only from the first cycle of the next period, or while disabled. Changes in mid-period do not alter the period in progress.
- R9: While reset is high or enable is low, both drives are low within one clock edge. After enable returns, counting restarts at 0 with values sampled on the enabling edge.
- R10: A window that stays active across a period boundary (high side with D > P, low side with D = 0) is not delayed again at the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; low forces both drives off |
| period_i | input | CNT_W | Terminal count P |
| duty_i | input | CNT_W | High-side compare value D |
| dead_i | input | DB_W | Turn-on dead time B in cycles |
| pwm_hi_o | output | 1 | High-side drive, active high |
| pwm_lo_o | output | 1 | Low-side drive, active high |

## Verification
The bench builds the block with CNT_W = 4 and DB_W = 3. This makes the full product of every terminal count, every compare value and every dead time small enough to sweep, over two periods for each combination. The sweep therefore reaches every corner of the window arithmetic: compare values of zero and above the period, dead times equal to or longer than either window, and a single-cycle period. Directed phases then change the values in mid-period and apply reset and disable while running, to exercise the shadow capture and the restart.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    // Timebase sequencing
    typedef enum logic {
        TB_HALT = 1'b0,
        TB_RUN  = 1'b1
    } tb_state_t;

    // Per-side dead-time sequencing
    typedef enum logic [1:0] {
        DB_IDLE = 2'd0,
        DB_WAIT = 2'd1,
        DB_FULL = 2'd2
    } db_state_t;

    localparam int unsigned NUM_SIDES = 2;
    localparam int unsigned SIDE_HI   = 0;
    localparam int unsigned SIDE_LO   = 1;

endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
    import cpwm_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned DB_W  = 7
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [DB_W-1:0]  dead_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] per_o,
    output logic [CNT_W-1:0] duty_o,
    output logic [DB_W-1:0]  dead_o,
    output logic             run_o
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    tb_state_t        state_q, state_nx;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] duty_q;
    logic [DB_W-1:0]  dead_q;
    logic             wrap;
    logic             load;

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= TB_HALT;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next state: START / STOP
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            TB_HALT: state_nx = en_i ? TB_RUN  : TB_HALT;
            TB_RUN:  state_nx = en_i ? TB_RUN  : TB_HALT;
            default: state_nx = TB_HALT;
        endcase
    end

    assign wrap = (state_q == TB_RUN) && (cnt_q == per_q);
    assign load = (state_q == TB_HALT) || !en_i || wrap;

    // Counter and shadow registers
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q  <= CNT_ZERO;
            per_q  <= '0;
            duty_q <= '0;
            dead_q <= '0;
        end else begin
            if (load) begin
                cnt_q  <= CNT_ZERO;
                per_q  <= period_i;
                duty_q <= duty_i;
                dead_q <= dead_i;
            end else begin
                cnt_q  <= cnt_q + CNT_ONE;
            end
        end
    end

    // Outputs
    always_comb begin
        cnt_o  = cnt_q;
        per_o  = per_q;
        duty_o = duty_q;
        dead_o = dead_q;
        run_o  = (state_q == TB_RUN);
    end

    // R1: the count never passes the terminal value and wraps from it
    assert_cnt_in_range_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == TB_RUN) |-> (cnt_q <= per_q));

    assert_wrap_to_zero_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        ((state_q == TB_RUN) && en_i && (cnt_q == per_q)) |=> (cnt_q == CNT_ZERO));

    // R8: shadows hold inside a running period
    assert_shadow_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        ((state_q == TB_RUN) && en_i && (cnt_q != per_q))
        |=> ($stable(per_q) && $stable(duty_q) && $stable(dead_q)));

    // R9: disabled means the count is back at zero
    assert_halt_clear_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (!en_i) |=> ((cnt_q == CNT_ZERO) && (state_q == TB_HALT)));

endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband
    import cpwm_pkg::*;
#(
    parameter int unsigned DB_W = 7
) (
    input  logic            clk_i,
    input  logic            clr_i,
    input  logic            want_i,
    input  logic [DB_W-1:0] dead_i,
    output logic            drive_o
);

    localparam logic [DB_W-1:0] RUN_MAX  = {DB_W{1'b1}};
    localparam logic [DB_W-1:0] RUN_ZERO = '0;
    localparam logic [DB_W-1:0] RUN_ONE  = DB_W'(1);

    db_state_t       state_q, state_nx;
    logic [DB_W-1:0] run_q, run_nx;

    // State register
    always_ff @(posedge clk_i) begin
        if (clr_i) begin
            state_q <= DB_IDLE;
            run_q   <= RUN_ZERO;
        end else begin
            state_q <= state_nx;
            run_q   <= run_nx;
        end
    end

    // Next state: OPEN / SATURATE / ABORT
    always_comb begin
        state_nx = state_q;
        run_nx   = run_q;
        unique case (state_q)
            DB_IDLE: begin
                if (want_i) begin
                    run_nx   = RUN_ONE;
                    state_nx = (RUN_ONE == RUN_MAX) ? DB_FULL : DB_WAIT;
                end else begin
                    run_nx   = RUN_ZERO;
                end
            end
            DB_WAIT: begin
                if (!want_i) begin
                    run_nx   = RUN_ZERO;
                    state_nx = DB_IDLE;
                end else begin
                    run_nx   = run_q + RUN_ONE;
                    state_nx = (run_q + RUN_ONE == RUN_MAX) ? DB_FULL : DB_WAIT;
                end
            end
            DB_FULL: begin
                if (!want_i) begin
                    run_nx   = RUN_ZERO;
                    state_nx = DB_IDLE;
                end
            end
            default: begin
                run_nx   = RUN_ZERO;
                state_nx = DB_IDLE;
            end
        endcase
    end

    // Output: turn-on held back, turn-off immediate
    always_comb begin
        drive_o = want_i && (run_q >= dead_i);
    end

    // R3: a drive never outlives its ideal window
    assert_turnoff_now_R3: assert property (@(posedge clk_i) disable iff (clr_i)
        (!want_i) |-> (!drive_o));

    // R3: a delayed rising edge needs the window open one cycle earlier
    assert_delayed_rise_R3: assert property (@(posedge clk_i) disable iff (clr_i)
        ($rose(drive_o) && (dead_i != RUN_ZERO)) |-> $past(want_i));

    // R4: the run counter is aborted when the window closes
    assert_abort_count_R4: assert property (@(posedge clk_i) disable iff (clr_i)
        (!want_i) |=> (run_q == RUN_ZERO));

endmodule

// File: rtl/cpwm_halfbridge.sv
module cpwm_halfbridge
    import cpwm_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned DB_W  = 7
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [DB_W-1:0]  dead_i,
    output logic             pwm_hi_o,
    output logic             pwm_lo_o
);

    logic [CNT_W-1:0]     cnt;
    logic [CNT_W-1:0]     per_q;
    logic [CNT_W-1:0]     duty_q;
    logic [DB_W-1:0]      dead_q;
    logic                 run;
    logic                 clr;
    logic                 below_duty;
    logic [NUM_SIDES-1:0] want;
    logic [NUM_SIDES-1:0] drive;

    cpwm_timebase #(
        .CNT_W (CNT_W),
        .DB_W  (DB_W)
    ) timebase_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .en_i     (en_i),
        .period_i (period_i),
        .duty_i   (duty_i),
        .dead_i   (dead_i),
        .cnt_o    (cnt),
        .per_o    (per_q),
        .duty_o   (duty_q),
        .dead_o   (dead_q),
        .run_o    (run)
    );

    assign clr        = rst_i || !en_i;
    assign below_duty = (cnt < duty_q);

    always_comb begin
        want          = '0;
        want[SIDE_HI] = run && below_duty;
        want[SIDE_LO] = run && !below_duty;
    end

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        cpwm_deadband #(
            .DB_W (DB_W)
        ) deadband_i (
            .clk_i   (clk_i),
            .clr_i   (clr),
            .want_i  (want[s]),
            .dead_i  (dead_q),
            .drive_o (drive[s])
        );
    end

    always_comb begin
        pwm_hi_o = drive[SIDE_HI];
        pwm_lo_o = drive[SIDE_LO];
    end

    // R5: shoot-through never commanded
    assert_no_overlap_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        !(pwm_hi_o && pwm_lo_o));

    // R6: zero dead time gives exact complement while running
    assert_exact_complement_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (run && (dead_q == '0)) |-> (pwm_hi_o != pwm_lo_o));

    // R9: disable drops both drives by the next edge
    assert_disable_off_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (!en_i) |=> (!pwm_hi_o && !pwm_lo_o));

    // R7: compare of zero keeps the high side off
    assert_zero_duty_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (duty_q == '0) |-> (!pwm_hi_o));

endmodule

// File: tb/cpwm_halfbridge_tb_top.sv
module cpwm_halfbridge_tb_top;

    localparam int CW = 4;
    localparam int BW = 3;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst;
    logic          en;
    logic [CW-1:0] per;
    logic [CW-1:0] duty;
    logic [BW-1:0] dead;
    logic          hi;
    logic          lo;

    always #4 clk = ~clk;

    cpwm_halfbridge #(.CNT_W(CW), .DB_W(BW)) dut_i (
        .clk_i(clk), .rst_i(rst), .en_i(en),
        .period_i(per), .duty_i(duty), .dead_i(dead),
        .pwm_hi_o(hi), .pwm_lo_o(lo)
    );

    int  total = 0;
    int  bad   = 0;
    int  cycles = 0;
    bit  done  = 0;

    // Reference model state
    bit  m_run = 0;
    int  m_t = 0, m_p = 0, m_d = 0, m_b = 0;
    int  r_hi = 0, r_lo = 0;
    int  stepno = 0;
    bit  prev_hi = 0;
    int  rise1 = -1, rise2 = -1;

    function automatic bit w_hi();
        return m_run && (m_t < m_d);
    endfunction

    function automatic bit w_lo();
        return m_run && (m_t >= m_d);
    endfunction

    function automatic string tag_hi();
        if (!m_run)       return "R9";
        if (m_d == 0)     return "R7";
        if (m_d > m_p)    return "R10";
        if (m_b == 0)     return "R2";
        if (m_b >= m_d)   return "R4";
        return "R3";
    endfunction

    function automatic string tag_lo();
        if (!m_run)               return "R9";
        if (m_d > m_p)            return "R7";
        if (m_d == 0)             return "R10";
        if (m_b == 0)             return "R6";
        if (m_b >= m_p + 1 - m_d) return "R4";
        return "R3";
    endfunction

    task automatic model_edge();
        bit wh;
        bit wl;
        wh = w_hi();
        wl = w_lo();
        if (rst) begin
            m_run = 0; m_t = 0; m_p = 0; m_d = 0; m_b = 0; r_hi = 0; r_lo = 0;
        end else if (!en) begin
            m_run = 0; m_t = 0; m_p = per; m_d = duty; m_b = dead; r_hi = 0; r_lo = 0;
        end else begin
            r_hi = wh ? ((r_hi < 255) ? r_hi + 1 : 255) : 0;
            r_lo = wl ? ((r_lo < 255) ? r_lo + 1 : 255) : 0;
            if (!m_run || m_t == m_p) begin
                m_run = 1; m_t = 0; m_p = per; m_d = duty; m_b = dead;
            end else begin
                m_t = m_t + 1;
            end
        end
    endtask

    task automatic check_bit(input bit act, input bit exp, input string req, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b (P=%0d D=%0d B=%0d t=%0d)",
                     req, what, act, exp, m_p, m_d, m_b, m_t);
        end
    endtask

    task automatic check_int(input int act, input int exp, input string req, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input string phase);
        bit eh;
        bit el;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        stepno++;
        eh = w_hi() && (r_hi >= m_b);
        el = w_lo() && (r_lo >= m_b);
        check_bit(hi, eh, (phase != "") ? phase : tag_hi(), "high-side drive");
        check_bit(lo, el, (phase != "") ? phase : tag_lo(), "low-side drive");
        check_bit(hi && lo, 1'b0, "R5", "overlap");
        if (hi && !prev_hi) begin
            if (rise1 < 0)      rise1 = stepno;
            else if (rise2 < 0) rise2 = stepno;
        end
        prev_hi = hi;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; en = 0; per = '0; duty = '0; dead = '0;
        // R9: reset state
        step("R9");
        step("R9");
        rst = 0;

        // Exhaustive sweep over P, D, B
        for (int p = 0; p < (1 << CW); p++) begin
            for (int d = 0; d < (1 << CW); d++) begin
                for (int b = 0; b < (1 << BW); b++) begin
                    per = p[CW-1:0]; duty = d[CW-1:0]; dead = b[BW-1:0]; en = 0;
                    step("");
                    en = 1;
                    stepno = 0; rise1 = -1; rise2 = -1;
                    for (int k = 0; k < 2 * p + 4; k++) step("");
                    // R1: period spacing of delayed rising edges
                    if (d > 0 && d <= p && b < d) begin
                        check_int(rise1, b + 1, "R3", "first rise step");
                        check_int(rise2 - rise1, p + 1, "R1", "rise spacing");
                    end
                end
            end
        end

        // R8: mid-period change waits for the boundary
        en = 0; per = 4'd9; duty = 4'd4; dead = 3'd1;
        step("R9");
        en = 1;
        for (int k = 0; k < 3; k++) step("R8");
        per = 4'd5; duty = 4'd2; dead = 3'd0;
        for (int k = 0; k < 7; k++) step("R8");
        check_int(m_p, 9, "R8", "old period still active before boundary");
        for (int k = 0; k < 16; k++) step("R8");

        // R9: reset while running, then restart
        rst = 1;
        step("R9");
        rst = 0; en = 0; per = 4'd6; duty = 4'd3; dead = 3'd2;
        step("R9");
        en = 1;
        for (int k = 0; k < 10; k++) step("");
        // R9: disable while running
        en = 0;
        step("R9");
        step("R9");

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule